// File: doc/BRIEF.md
# Trigger Matching Window Selector

This block decides which time-stamped hits belong to each trigger. It keeps a free-running coarse time base, stamps every incoming hit and trigger with the time base value of the cycle in which it arrives, and queues the hits. Each trigger defines an acceptance window. The window begins at the trigger stamp plus a signed offset and spans a programmable width, both counted in base clock cycles. Once a window has closed, the block emits an event: a header, then every queued hit whose stamp lies inside the window, then a trailer.

Windows may be wider than the trigger period, so that they overlap. A repetitive trigger then gives capture with no gaps, and a hit that lies inside two windows is reported in both events. A hit that can no longer fall inside any current or future window is discarded. In continuous mode, matching is bypassed and every hit is forwarded as it leaves the queue. A clear input flushes all pending state, and a bunch-count reset input zeroes the time base.

Top module: `trig_match_window`

## Requirements
- R1: The coarse time base advances by one each clock. When bc_reset is high in a cycle, the time base reads 0 in the next cycle. A hit or trigger is stamped with the time base value of the cycle in which its input is high.
- R2: In triggered mode (mode_cont=0), a hit is part of an event when (hit_stamp - (trig_stamp + cfg_offset)) mod 2^16 <= cfg_width. Both window edges are inclusive.
- R3: Each event is framed as follows, and events are emitted in trigger order.
  - First a header: out_kind=0, out_tag=event count, out_time=trigger stamp.
  - Then the matched hits in arrival order: out_kind=1, out_tag=channel, out_time=hit stamp.
  - Then a trailer: out_kind=2, out_tag=0, out_time=number of matched hits.
  - The event count is 0 after reset or clear and rises by one per event.
  - A header is followed, cycle after cycle, by its hits and then its trailer.
- R4: A hit outside every window is never output.
- R5: When windows overlap, a hit inside several windows appears in each of those events.
- R6: A window that ends after its trigger is emitted only once it has closed. It includes hits that arrive after the trigger.
- R7: A periodic trigger with width >= period and offset = -width reports every hit stamped from the first window start up to the last trigger.
- R8: Window membership and stamps stay correct when the time base rolls over from 65535 to 0.
- R9: In continuous mode (mode_cont=1), every hit is output with out_kind=1 in arrival order. Triggers are ignored, and no header or trailer is produced.
- R10: A clear discards every queued hit and pending trigger, leaves the output idle in the next cycle, and resets the event count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Flush queued hits and triggers and restart event numbering |
| bc_reset | input | 1 | Zero the coarse time base |
| mode_cont | input | 1 | 1 = continuous pass-through, 0 = triggered matching |
| cfg_offset | input | 13 | Signed window start relative to the trigger, in cycles |
| cfg_width | input | 12 | Window width in cycles |
| trig_in | input | 1 | Trigger pulse |
| hit_valid | input | 1 | A hit arrives this cycle |
| hit_chan | input | 5 | Channel of the arriving hit |
| out_valid | output | 1 | Output word valid |
| out_kind | output | 2 | 0 header, 1 hit, 2 trailer |
| out_tag | output | 12 | Event count or channel |
| out_time | output | 16 | Trigger stamp, hit stamp or hit count |

## Verification
The bench places hits one cycle outside and exactly on each window edge. A design with an off-by-one compare would lose an edge hit or gain an outside one. Overlapping windows catch a design that consumes a hit when it first reports it, because that hit would then be missing from the second event. A window that extends past its trigger catches a design that closes the event too early and misses the later hits. A window that straddles the time base rollover catches a design that compares stamps without modular arithmetic. A clear issued while a trigger is waiting on an open window must suppress that event and restart numbering at 0. A design that only flushed the output would still report the stale event.

// File: rtl/tmw_pkg.sv
`timescale 1ns/1ps
package tmw_pkg;
  typedef enum logic [1:0] {
    K_HEAD  = 2'd0,
    K_HIT   = 2'd1,
    K_TRAIL = 2'd2
  } kind_t;
endpackage

// File: rtl/tmw_timebase.sv
`timescale 1ns/1ps
module tmw_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bc_reset,
  output logic [CNT_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst || bc_reset) now <= '0;
    else                 now <= now + 1'b1;
  end
endmodule

// File: rtl/tmw_fifo.sv
`timescale 1ns/1ps
module tmw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic          empty,
  output logic [AW:0]   rd_ptr,
  output logic [AW:0]   wr_ptr,
  output logic [W-1:0]  head,
  input  logic [AW-1:0] peek_addr,
  output logic [W-1:0]  peek_data
);
  logic [W-1:0] mem [DEPTH];
  logic full, do_push, do_pop;

  assign empty   = (rd_ptr == wr_ptr);
  assign full    = (rd_ptr[AW] != wr_ptr[AW]) && (rd_ptr[AW-1:0] == wr_ptr[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= din;
  end

  assign head      = mem[rd_ptr[AW-1:0]];
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tmw_matcher.sv
`timescale 1ns/1ps
module tmw_matcher
  import tmw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WID_W = 12,
  parameter int OFS_W = 13,
  parameter int CH_W  = 5,
  parameter int EVT_W = 12,
  parameter int HAW   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    mode_cont,
  input  logic [CNT_W-1:0]        now,
  input  logic signed [OFS_W-1:0] cfg_offset,
  input  logic [WID_W-1:0]        cfg_width,
  input  logic                    h_empty,
  input  logic [HAW:0]            h_rd_ptr,
  input  logic [HAW:0]            h_wr_ptr,
  input  logic [CH_W+CNT_W-1:0]   h_head,
  output logic [HAW-1:0]          h_peek_addr,
  input  logic [CH_W+CNT_W-1:0]   h_peek_data,
  output logic                    h_pop,
  input  logic                    t_empty,
  input  logic [CNT_W-1:0]        t_head,
  output logic                    t_pop,
  output logic                    out_valid,
  output logic [1:0]              out_kind,
  output logic [EVT_W-1:0]        out_tag,
  output logic [CNT_W-1:0]        out_time
);
  typedef enum logic {S_IDLE, S_SCAN} state_t;
  state_t state;

  logic [HAW:0]       scan_ptr;
  logic [CNT_W-1:0]   hit_cnt;
  logic [EVT_W-1:0]   evt_cnt;
  logic [CNT_W-1:0]   ofs_ext, width_ext;
  logic [CNT_W-1:0]   win_start, win_end, earliest;
  logic [CNT_W-1:0]   head_rel, close_rel, scan_rel;
  logic               head_dead, closed, scan_in;
  logic [CNT_W-1:0]   head_ts, scan_ts;
  logic [CH_W-1:0]    head_ch, scan_ch;

  assign ofs_ext   = {{(CNT_W-OFS_W){cfg_offset[OFS_W-1]}}, cfg_offset};
  assign width_ext = {{(CNT_W-WID_W){1'b0}}, cfg_width};

  assign head_ts = h_head[CNT_W-1:0];
  assign head_ch = h_head[CH_W+CNT_W-1:CNT_W];
  assign scan_ts = h_peek_data[CNT_W-1:0];
  assign scan_ch = h_peek_data[CH_W+CNT_W-1:CNT_W];

  // window of the oldest pending trigger
  assign win_start = t_head + ofs_ext;
  assign win_end   = win_start + width_ext;
  // no future window can start before this point
  assign earliest  = t_empty ? (now + ofs_ext) : win_start;

  assign head_rel  = head_ts - earliest;
  assign head_dead = !h_empty && head_rel[CNT_W-1];

  assign close_rel = now - win_end;
  assign closed    = !t_empty && !close_rel[CNT_W-1] && (close_rel != '0);

  assign scan_rel  = scan_ts - win_start;
  assign scan_in   = (scan_ptr != h_wr_ptr) && !scan_rel[CNT_W-1] && (scan_rel <= width_ext);

  assign h_peek_addr = scan_ptr[HAW-1:0];
  assign h_pop = (state == S_IDLE) && (mode_cont ? !h_empty : head_dead);
  assign t_pop = ((state == S_SCAN) && !scan_in) || ((state == S_IDLE) && mode_cont);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state     <= S_IDLE;
      scan_ptr  <= '0;
      hit_cnt   <= '0;
      evt_cnt   <= '0;
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_tag   <= '0;
      out_time  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (mode_cont) begin
            if (!h_empty) begin
              out_valid <= 1'b1;
              out_kind  <= K_HIT;
              out_tag   <= {{(EVT_W-CH_W){1'b0}}, head_ch};
              out_time  <= head_ts;
            end
          end else if (!head_dead && closed) begin
            out_valid <= 1'b1;
            out_kind  <= K_HEAD;
            out_tag   <= evt_cnt;
            out_time  <= t_head;
            scan_ptr  <= h_rd_ptr;
            hit_cnt   <= '0;
            state     <= S_SCAN;
          end
        end
        S_SCAN: begin
          out_valid <= 1'b1;
          if (scan_in) begin
            out_kind <= K_HIT;
            out_tag  <= {{(EVT_W-CH_W){1'b0}}, scan_ch};
            out_time <= scan_ts;
            hit_cnt  <= hit_cnt + 1'b1;
            scan_ptr <= scan_ptr + 1'b1;
          end else begin
            out_kind <= K_TRAIL;
            out_tag  <= '0;
            out_time <= hit_cnt;
            evt_cnt  <= evt_cnt + 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_match_window.sv
`timescale 1ns/1ps
module trig_match_window #(
  parameter int CNT_W     = 16,
  parameter int WID_W     = 12,
  parameter int OFS_W     = 13,
  parameter int CH_W      = 5,
  parameter int EVT_W     = 12,
  parameter int HIT_DEPTH = 16,
  parameter int TRG_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    bc_reset,
  input  logic                    mode_cont,
  input  logic signed [OFS_W-1:0] cfg_offset,
  input  logic [WID_W-1:0]        cfg_width,
  input  logic                    trig_in,
  input  logic                    hit_valid,
  input  logic [CH_W-1:0]         hit_chan,
  output logic                    out_valid,
  output logic [1:0]              out_kind,
  output logic [EVT_W-1:0]        out_tag,
  output logic [CNT_W-1:0]        out_time
);
  localparam int HAW = $clog2(HIT_DEPTH);
  localparam int TAW = $clog2(TRG_DEPTH);
  localparam int HW  = CH_W + CNT_W;

  logic [CNT_W-1:0] now;
  logic             h_empty, h_pop, t_empty, t_pop;
  logic [HAW:0]     h_rd_ptr, h_wr_ptr;
  logic [HW-1:0]    h_head, h_peek_data;
  logic [HAW-1:0]   h_peek_addr;
  logic [CNT_W-1:0] t_head, trg_peek_unused;
  logic [TAW:0]     trg_rd_unused, trg_wr_unused;

  tmw_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk(clk), .rst(rst), .bc_reset(bc_reset), .now(now)
  );

  tmw_fifo #(.W(HW), .DEPTH(HIT_DEPTH)) u_hit_q (
    .clk(clk), .rst(rst), .flush(clear),
    .push(hit_valid), .din({hit_chan, now}), .pop(h_pop),
    .empty(h_empty), .rd_ptr(h_rd_ptr), .wr_ptr(h_wr_ptr), .head(h_head),
    .peek_addr(h_peek_addr), .peek_data(h_peek_data)
  );

  tmw_fifo #(.W(CNT_W), .DEPTH(TRG_DEPTH)) u_trig_q (
    .clk(clk), .rst(rst), .flush(clear),
    .push(trig_in && !mode_cont), .din(now), .pop(t_pop),
    .empty(t_empty), .rd_ptr(trg_rd_unused), .wr_ptr(trg_wr_unused), .head(t_head),
    .peek_addr('0), .peek_data(trg_peek_unused)
  );

  tmw_matcher #(
    .CNT_W(CNT_W), .WID_W(WID_W), .OFS_W(OFS_W), .CH_W(CH_W), .EVT_W(EVT_W), .HAW(HAW)
  ) u_matcher (
    .clk(clk), .rst(rst), .clear(clear), .mode_cont(mode_cont), .now(now),
    .cfg_offset(cfg_offset), .cfg_width(cfg_width),
    .h_empty(h_empty), .h_rd_ptr(h_rd_ptr), .h_wr_ptr(h_wr_ptr), .h_head(h_head),
    .h_peek_addr(h_peek_addr), .h_peek_data(h_peek_data), .h_pop(h_pop),
    .t_empty(t_empty), .t_head(t_head), .t_pop(t_pop),
    .out_valid(out_valid), .out_kind(out_kind), .out_tag(out_tag), .out_time(out_time)
  );
endmodule

// File: rtl/tmw_checker.sv
`timescale 1ns/1ps
module tmw_checker #(
  parameter int CNT_W = 16,
  parameter int WID_W = 12,
  parameter int OFS_W = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clear,
  input logic                    bc_reset,
  input logic                    mode_cont,
  input logic signed [OFS_W-1:0] cfg_offset,
  input logic [WID_W-1:0]        cfg_width,
  input logic                    out_valid,
  input logic [1:0]              out_kind,
  input logic [CNT_W-1:0]        out_time,
  input logic [CNT_W-1:0]        now
);
  logic             in_evt;
  logic [CNT_W-1:0] hdr_t, seen;
  logic [CNT_W-1:0] ofs_ext, width_ext, rel;

  assign ofs_ext   = {{(CNT_W-OFS_W){cfg_offset[OFS_W-1]}}, cfg_offset};
  assign width_ext = {{(CNT_W-WID_W){1'b0}}, cfg_width};
  assign rel       = out_time - (hdr_t + ofs_ext);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      in_evt <= 1'b0;
      hdr_t  <= '0;
      seen   <= '0;
    end else if (out_valid) begin
      if (out_kind == 2'd0) begin
        in_evt <= 1'b1;
        hdr_t  <= out_time;
        seen   <= '0;
      end else if (out_kind == 2'd1) begin
        if (in_evt) seen <= seen + 1'b1;
      end else begin
        in_evt <= 1'b0;
      end
    end
  end

  AST_BCR_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(bc_reset) |-> (now == '0)); // R1

  AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst || clear)
    (out_valid && out_kind == 2'd1 && in_evt) |-> (rel <= width_ext)); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_kind != 2'd3)); // R3

  AST_HEAD_CONTIG: assert property (@(posedge clk) disable iff (rst || clear)
    (out_valid && out_kind == 2'd0) |=> (out_valid && out_kind != 2'd0)); // R3

  AST_TRAIL_COUNT: assert property (@(posedge clk) disable iff (rst || clear)
    (out_valid && out_kind == 2'd2) |-> (in_evt && out_time == seen)); // R3

  AST_CONT_NO_HEAD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd0) |-> !$past(mode_cont)); // R9

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> !out_valid); // R10
endmodule

bind trig_match_window tmw_checker #(.CNT_W(CNT_W), .WID_W(WID_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear), .bc_reset(bc_reset), .mode_cont(mode_cont),
  .cfg_offset(cfg_offset), .cfg_width(cfg_width), .out_valid(out_valid),
  .out_kind(out_kind), .out_time(out_time), .now(now)
);

// File: tb/trig_match_window_bench.sv
`timescale 1ns/1ps
module trig_match_window_bench;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               clear = 1'b0;
  logic               bc_reset = 1'b0;
  logic               mode_cont = 1'b0;
  logic signed [12:0] cfg_offset = '0;
  logic [11:0]        cfg_width = '0;
  logic               trig_in = 1'b0;
  logic               hit_valid = 1'b0;
  logic [4:0]         hit_chan = '0;
  logic               out_valid;
  logic [1:0]         out_kind;
  logic [11:0]        out_tag;
  logic [15:0]        out_time;

  trig_match_window u_trig_match_window (
    .clk(clk), .rst(rst), .clear(clear), .bc_reset(bc_reset), .mode_cont(mode_cont),
    .cfg_offset(cfg_offset), .cfg_width(cfg_width), .trig_in(trig_in),
    .hit_valid(hit_valid), .hit_chan(hit_chan), .out_valid(out_valid),
    .out_kind(out_kind), .out_tag(out_tag), .out_time(out_time)
  );

  always #4 clk = ~clk;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  int    exp_kind[$];
  int    exp_tag[$];
  int    exp_time[$];
  string exp_req[$];
  int    hq[$];
  int    tq[$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_item(input int k, input int tg, input int tm, input string req);
    exp_kind.push_back(k);
    exp_tag.push_back(tg);
    exp_time.push_back(tm & 16'hFFFF);
    exp_req.push_back(req);
  endtask

  // monitor: pops expected items as outputs appear
  int    m_k, m_t, m_tm;
  string m_r;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_kind.size() == 0) begin
        check(1'b0, "R4", "unexpected output kind", int'(out_kind), -1);
      end else begin
        m_k  = exp_kind.pop_front();
        m_t  = exp_tag.pop_front();
        m_tm = exp_time.pop_front();
        m_r  = exp_req.pop_front();
        check(int'(out_kind) == m_k, m_r, "kind", int'(out_kind), m_k);
        check(int'(out_tag) == m_t, m_r, "tag", int'(out_tag), m_t);
        check(int'(out_time) == m_tm, m_r, "time", int'(out_time), m_tm);
      end
    end
  end

  // driver: models the expected stream from hq/tq, then drives them
  task automatic run_case(input bit cont, input int ofs, input int wid, input int skip,
                          input int clr_at, input string req);
    int evt;
    int last;
    evt = 0;
    last = clr_at;
    foreach (hq[k]) if (hq[k] > last) last = hq[k];
    foreach (tq[j]) if (tq[j] > last) last = tq[j];
    if (cont) begin
      foreach (hq[k]) if (hq[k] > clr_at) expect_item(1, k % 32, skip + hq[k], req);
    end else begin
      foreach (tq[j]) begin
        if (tq[j] > clr_at) begin
          int n;
          n = 0;
          expect_item(0, evt, skip + tq[j], req);
          foreach (hq[k]) begin
            if (hq[k] > clr_at && (((hq[k] - tq[j] - ofs) & 16'hFFFF) <= wid)) begin
              expect_item(1, k % 32, skip + hq[k], req);
              n++;
            end
          end
          expect_item(2, 0, n, req);
          evt++;
        end
      end
    end
    @(negedge clk);
    clear = 1'b1;
    mode_cont = cont;
    cfg_offset = 13'(ofs);
    cfg_width = 12'(wid);
    @(negedge clk);
    clear = 1'b0;
    bc_reset = 1'b1;
    @(negedge clk);
    bc_reset = 1'b0;
    repeat (skip) @(negedge clk);
    for (int i = 0; i <= last; i++) begin
      hit_valid = 1'b0;
      trig_in = 1'b0;
      clear = (i == clr_at);
      foreach (hq[k]) if (hq[k] == i) begin hit_valid = 1'b1; hit_chan = 5'(k % 32); end
      foreach (tq[j]) if (tq[j] == i) trig_in = 1'b1;
      @(negedge clk);
    end
    hit_valid = 1'b0;
    trig_in = 1'b0;
    clear = 1'b0;
    repeat (300) @(negedge clk);
    check(exp_kind.size() == 0, req, "outputs still missing", exp_kind.size(), 0);
    exp_kind.delete(); exp_tag.delete(); exp_time.delete(); exp_req.delete();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R3", "out_valid after reset", int'(out_valid), 0);

    // R1 R2 R3 R4: edges inclusive, neighbours outside dropped
    hq = '{5, 29, 30, 45, 50, 51}; tq = '{50};
    run_case(1'b0, -20, 20, 0, -1, "R1 R2 R3 R4");

    // R5: overlapping windows report a shared hit twice
    hq = '{60, 95, 105, 121}; tq = '{100, 120};
    run_case(1'b0, -30, 30, 0, -1, "R5");

    // R6: window entirely after the trigger
    hq = '{25, 30, 40, 45, 46}; tq = '{20};
    run_case(1'b0, 10, 15, 0, -1, "R6");

    // R7: periodic trigger, width above period, gapless coverage
    hq.delete();
    for (int h = 3; h <= 206; h += 7) hq.push_back(h);
    tq = '{60, 110, 160, 210};
    run_case(1'b0, -52, 52, 0, -1, "R7");

    // R9: continuous mode, triggers ignored
    hq = '{3, 4, 10, 20}; tq = '{5, 15};
    run_case(1'b1, -20, 20, 0, -1, "R9");

    // R10: clear while a window is still open
    hq = '{20, 65, 100}; tq = '{10, 45};
    run_case(1'b0, 50, 20, 0, 40, "R10");

    // R8: window straddling the time base rollover
    hq = '{0, 2, 10, 16, 19, 24, 27}; tq = '{20};
    run_case(1'b0, -20, 25, 65520, -1, "R8");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R3", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end
endmodule